// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM

This block is a dual-port memory whose two ports see one shared store at different widths. The wide port moves 16-bit words and has a per-byte write mask. The narrow port moves single bytes. Both ports address the same bytes, and the byte order between them is fixed as little-endian. Wide word `w` holds byte `2w` in its low half and byte `2w+1` in its high half. The narrow port reaches byte `b` as lane `b[0]` of word `b>>1`. The array never swaps bytes. A consumer that wants big-endian presentation must reorder the bytes outside the block.

Each port has its own enable, address, write strobe, write data and registered read data, and both ports run on one clock. A parameter selects between two port modes. In the full two-way mode, either port may read or write in any cycle. In the one-way mode, the wide port only writes and the narrow port only reads. The store starts from an image that is computed at elaboration with no file involved. The image can be all zeros, each byte equal to its own address, or a repeating 32-bit pattern given as a parameter.

A write from both ports to the same byte in the same cycle leaves that byte undefined. The block does not detect this case, and users must avoid it.

Top module: `mwram_top`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first enabled read, both `a_rdata` and `b_rdata` read as zero.
- R2: The mapping is little-endian. Bits [7:0] of wide word `w` are byte `2w` and bits [15:8] are byte `2w+1`. A narrow access to byte `b` touches lane `b[0]` of word `b>>1`. For example, writing 0x1234 to word 0 makes byte 0 read 0x34 and byte 1 read 0x12.
- R3: On a wide write, `a_be[0]` enables the low byte (byte `2w`) and `a_be[1]` enables the high byte (byte `2w+1`). A byte whose enable bit is 0 keeps its old value. A mask of 00 changes nothing.
- R4: Read data appears one clock after the edge at which the enabled access is sampled. It then holds until the next enabled access on that port.
- R5: A read returns the contents from before any write in the same cycle. This holds when the write comes from the same port and when it comes from the other port.
- R6: With a port's enable low, its write strobe and data have no effect on the store, and its read data holds.
- R7: With the address image, byte `b` starts as `b mod 256`, so wide word 0 reads 0x0100 and narrow byte 0 reads 0x00. With the pattern image, byte `b` starts as bits `[8*(b mod 4)+7 : 8*(b mod 4)]` of the pattern.
- R8: In two-way mode, any mix of wide and narrow reads and writes matches a byte-array model, provided the two ports never write the same byte in the same cycle.
- R9: In one-way mode, `a_rdata` stays zero, and `b_we` and `b_wdata` have no effect. Narrow reads return the bytes that the wide port wrote.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| a_en | input | 1 | Wide port access enable |
| a_we | input | 1 | Wide port write strobe, used when `a_en` is high |
| a_be | input | 2 | Wide port byte write mask (bit 0 = low byte) |
| a_addr | input | 8 | Wide port word address |
| a_wdata | input | 16 | Wide port write data |
| a_rdata | output | 16 | Wide port registered read data |
| b_en | input | 1 | Narrow port access enable |
| b_we | input | 1 | Narrow port write strobe, used when `b_en` is high |
| b_addr | input | 9 | Narrow port byte address |
| b_wdata | input | 8 | Narrow port write data |
| b_rdata | output | 8 | Narrow port registered read data |

## Verification
All read results come out exactly one clock after the rising edge that samples the enabled access. A write first becomes visible to a read that is sampled at a later edge, on either port. The bench changes its inputs at falling edges. Its behavioural byte-array model updates at each rising edge, taking the expected read values before it applies that cycle's writes. Both ports of both configurations are compared with the model at the next falling edge. Directed checks sample at the falling edge that follows the access cycle, and the random traffic never lets both ports write one byte in the same cycle.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int WIDE_W = BYTE_W * LANES;

    typedef enum logic {
        MODE_SIMPLE = 1'b0,
        MODE_TRUE   = 1'b1
    } port_mode_e;

    typedef enum logic [1:0] {
        INIT_ZERO    = 2'd0,
        INIT_ADDR    = 2'd1,
        INIT_PATTERN = 2'd2
    } init_kind_e;

    // Start-up value of one byte of the store, given its byte address.
    function automatic logic [BYTE_W-1:0] init_byte(input init_kind_e kind,
                                                    input int unsigned addr,
                                                    input logic [31:0] pat);
        logic [BYTE_W-1:0] v;
        v = '0;
        unique case (kind)
            INIT_ADDR:    v = addr[BYTE_W-1:0];
            INIT_PATTERN: v = pat[BYTE_W*(addr % 4) +: BYTE_W];
            default:      v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/mwram_lane.sv
// One byte lane of the store: every word of this lane, shared by the wide
// port (one lane of its word) and the narrow port (whole byte).
module mwram_lane
    import mwram_pkg::*;
#(
    parameter int          WORDS     = 256,
    parameter int          LANE      = 0,
    parameter init_kind_e  INIT_KIND = INIT_ADDR,
    parameter logic [31:0] INIT_PAT  = 32'h0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wa_en,
    input  logic                     wa_we,
    input  logic [$clog2(WORDS)-1:0] wa_addr,
    input  logic [BYTE_W-1:0]        wa_wdata,
    output logic [BYTE_W-1:0]        wa_rdata,
    input  logic                     nb_en,
    input  logic                     nb_we,
    input  logic [$clog2(WORDS)-1:0] nb_addr,
    input  logic [BYTE_W-1:0]        nb_wdata,
    output logic [BYTE_W-1:0]        nb_rdata
);

    logic [BYTE_W-1:0] mem [WORDS];

    initial begin
        for (int w = 0; w < WORDS; w++) begin
            mem[w] <= init_byte(INIT_KIND, LANES * w + LANE, INIT_PAT);
        end
    end

    // Store update; the narrow port is applied last (same-byte collision is undefined).
    always @(posedge clk) begin
        if (wa_we) mem[wa_addr] <= wa_wdata;
        if (nb_we) mem[nb_addr] <= nb_wdata;
    end

    // Read registers see the store before this edge's writes (read-first).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wa_rdata <= '0;
            nb_rdata <= '0;
        end else begin
            if (wa_en) wa_rdata <= mem[wa_addr];
            if (nb_en) nb_rdata <= mem[nb_addr];
        end
    end

    assert_hold_wide_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        !wa_en |=> $stable(wa_rdata));

    assert_hold_narrow_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        !nb_en |=> $stable(nb_rdata));

endmodule

// File: rtl/mwram_nsel.sv
// Narrow-port steering: splits the byte address into word and lane,
// strobes one lane, and picks the returned byte with a registered select.
module mwram_nsel
    import mwram_pkg::*;
#(
    parameter int AW_B = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         nb_en,
    input  logic                         nb_we,
    input  logic [AW_B-1:0]              nb_addr,
    output logic [AW_B-2:0]              lane_addr,
    output logic [LANES-1:0]             lane_en,
    output logic [LANES-1:0]             lane_we,
    input  logic [LANES-1:0][BYTE_W-1:0] lane_q,
    output logic [BYTE_W-1:0]            nb_rdata
);

    localparam int SW = $clog2(LANES);

    logic [SW-1:0] sel_q;

    assign lane_addr = nb_addr[AW_B-1:SW];

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_dec
            assign lane_en[i] = nb_en && (nb_addr[SW-1:0] == SW'(i));
            assign lane_we[i] = lane_en[i] && nb_we;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (nb_en) begin
            sel_q <= nb_addr[SW-1:0];
        end
    end

    assign nb_rdata = lane_q[sel_q];

endmodule

// File: rtl/mwram_top.sv
module mwram_top
    import mwram_pkg::*;
#(
    parameter int          DEPTH_BYTES = 512,
    parameter port_mode_e  MODE        = MODE_TRUE,
    parameter init_kind_e  INIT_KIND   = INIT_ADDR,
    parameter logic [31:0] INIT_PAT    = 32'h0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               a_en,
    input  logic                               a_we,
    input  logic [1:0]                         a_be,
    input  logic [$clog2(DEPTH_BYTES)-2:0]     a_addr,
    input  logic [15:0]                        a_wdata,
    output logic [15:0]                        a_rdata,
    input  logic                               b_en,
    input  logic                               b_we,
    input  logic [$clog2(DEPTH_BYTES)-1:0]     b_addr,
    input  logic [7:0]                         b_wdata,
    output logic [7:0]                         b_rdata
);

    localparam int WORDS = DEPTH_BYTES / LANES;
    localparam int AW_A  = $clog2(WORDS);
    localparam int AW_B  = AW_A + 1;

    logic                         b_we_eff;
    logic [LANES-1:0][BYTE_W-1:0] lane_qa;
    logic [LANES-1:0][BYTE_W-1:0] lane_qb;
    logic [AW_A-1:0]              nb_word;
    logic [LANES-1:0]             nb_en_l;
    logic [LANES-1:0]             nb_we_l;

    // Port mode variant.
    generate
        if (MODE == MODE_TRUE) begin : g_true
            assign b_we_eff = b_we;
            assign a_rdata  = lane_qa;

            assert_wide_roundtrip_R8 : assert property (@(posedge clk) disable iff (!rst_n)
                (a_en && a_we && a_be == 2'b11 && !(b_en && b_we))
                ##1 (a_en && !a_we && a_addr == $past(a_addr))
                |=> (a_rdata == $past(a_wdata, 2)));

            assert_narrow_to_wide_R2 : assert property (@(posedge clk) disable iff (!rst_n)
                (b_en && b_we && !(a_en && a_we))
                ##1 (a_en && !a_we && a_addr == $past(b_addr[AW_B-1:1]))
                |=> ((($past(b_addr[0], 2)) ? a_rdata[15:8] : a_rdata[7:0]) == $past(b_wdata, 2)));
        end else begin : g_simple
            assign b_we_eff = 1'b0;
            assign a_rdata  = '0;
        end
    endgenerate

    mwram_nsel #(
        .AW_B (AW_B)
    ) u_nsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .nb_en     (b_en),
        .nb_we     (b_we_eff),
        .nb_addr   (b_addr),
        .lane_addr (nb_word),
        .lane_en   (nb_en_l),
        .lane_we   (nb_we_l),
        .lane_q    (lane_qb),
        .nb_rdata  (b_rdata)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            mwram_lane #(
                .WORDS     (WORDS),
                .LANE      (i),
                .INIT_KIND (INIT_KIND),
                .INIT_PAT  (INIT_PAT)
            ) u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .wa_en    (a_en),
                .wa_we    (a_en && a_we && a_be[i]),
                .wa_addr  (a_addr),
                .wa_wdata (a_wdata[BYTE_W*i +: BYTE_W]),
                .wa_rdata (lane_qa[i]),
                .nb_en    (nb_en_l[i]),
                .nb_we    (nb_we_l[i]),
                .nb_addr  (nb_word),
                .nb_wdata (b_wdata),
                .nb_rdata (lane_qb[i])
            );
        end
    endgenerate

    assert_reset_clear_R1 : assert property (@(posedge clk)
        !rst_n |=> (a_rdata == '0 && b_rdata == '0));

    assert_wide_to_narrow_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we && a_be[0] && !(b_en && b_we))
        ##1 (b_en && !b_we && b_addr == {$past(a_addr), 1'b0})
        |=> (b_rdata == $past(a_wdata[7:0], 2)));

endmodule

// File: tb/mwram_top_tb_top.sv
module mwram_top_tb_top;
    import mwram_pkg::*;

    localparam int          DEPTH = 512;
    localparam int          AWA   = 8;
    localparam int          AWB   = 9;
    localparam logic [31:0] PAT   = 32'h5AC3_1E87;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // Two-way instance (address image)
    logic a_en, a_we, b_en, b_we;
    logic [1:0] a_be;
    logic [AWA-1:0] a_addr;
    logic [AWB-1:0] b_addr;
    logic [15:0] a_wdata, a_rdata;
    logic [7:0] b_wdata, b_rdata;
    // One-way instance (pattern image)
    logic sa_en, sa_we, sb_en, sb_we;
    logic [1:0] sa_be;
    logic [AWA-1:0] sa_addr;
    logic [AWB-1:0] sb_addr;
    logic [15:0] sa_wdata, sa_rdata;
    logic [7:0] sb_wdata, sb_rdata;

    mwram_top #(.DEPTH_BYTES(DEPTH), .MODE(MODE_TRUE), .INIT_KIND(INIT_ADDR), .INIT_PAT(32'h0)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_en(a_en), .a_we(a_we), .a_be(a_be), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata));

    mwram_top #(.DEPTH_BYTES(DEPTH), .MODE(MODE_SIMPLE), .INIT_KIND(INIT_PATTERN), .INIT_PAT(PAT)) dut_s_i (
        .clk(clk), .rst_n(rst_n), .a_en(sa_en), .a_we(sa_we), .a_be(sa_be), .a_addr(sa_addr),
        .a_wdata(sa_wdata), .a_rdata(sa_rdata), .b_en(sb_en), .b_we(sb_we), .b_addr(sb_addr),
        .b_wdata(sb_wdata), .b_rdata(sb_rdata));

    int n_chk = 0;
    int n_bad = 0;
    bit live = 1'b0;
    string tag = "R1";

    logic [7:0] mt [DEPTH];
    logic [7:0] ms [DEPTH];
    logic [15:0] ea, esa;
    logic [7:0] eb, esb;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mt[i] = i[7:0];
            ms[i] = PAT[8*(i%4) +: 8];
        end
        ea = '0; eb = '0; esa = '0; esb = '0;
    end

    // Behavioural reference: reads take the bytes before this edge's writes.
    always @(posedge clk) begin
        if (!rst_n) begin
            ea = '0; eb = '0; esa = '0; esb = '0;
        end else begin
            if (a_en) ea = {mt[2*a_addr+1], mt[2*a_addr]};
            if (b_en) eb = mt[b_addr];
            if (a_en && a_we) begin
                if (a_be[0]) mt[2*a_addr]   = a_wdata[7:0];
                if (a_be[1]) mt[2*a_addr+1] = a_wdata[15:8];
            end
            if (b_en && b_we) mt[b_addr] = b_wdata;
            if (sb_en) esb = ms[sb_addr];
            if (sa_en && sa_we) begin
                if (sa_be[0]) ms[2*sa_addr]   = sa_wdata[7:0];
                if (sa_be[1]) ms[2*sa_addr+1] = sa_wdata[15:8];
            end
        end
    end

    always @(negedge clk) begin
        if (live) begin
            chk(a_rdata === ea, tag, "wide read", a_rdata, ea);
            chk(b_rdata === eb, tag, "narrow read", b_rdata, eb);
            chk(sa_rdata === esa, "R9", "one-way wide read", sa_rdata, esa);
            chk(sb_rdata === esb, "R9", "one-way narrow read", sb_rdata, esb);
        end
    end

    task automatic idle();
        a_en = 0; a_we = 0; a_be = 2'b00; a_addr = '0; a_wdata = '0;
        b_en = 0; b_we = 0; b_addr = '0; b_wdata = '0;
        sa_en = 0; sa_we = 0; sa_be = 2'b00; sa_addr = '0; sa_wdata = '0;
        sb_en = 0; sb_we = 0; sb_addr = '0; sb_wdata = '0;
    endtask

    task automatic awr(input int w, input logic [1:0] be, input logic [15:0] d);
        a_en = 1; a_we = 1; a_be = be; a_addr = AWA'(w); a_wdata = d;
    endtask

    task automatic ard(input int w);
        a_en = 1; a_we = 0; a_be = 2'b00; a_addr = AWA'(w);
    endtask

    task automatic brd(input int b);
        b_en = 1; b_we = 0; b_addr = AWB'(b);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        idle();
        repeat (4) @(negedge clk);
        chk(a_rdata == 16'h0, "R1", "wide in reset", a_rdata, 0);
        chk(b_rdata == 8'h0, "R1", "narrow in reset", b_rdata, 0);
        rst_n = 1;
        @(negedge clk);
        chk(a_rdata == 16'h0, "R1", "wide after reset", a_rdata, 0);
        chk(sb_rdata == 8'h0, "R1", "narrow after reset", sb_rdata, 0);
        live = 1;

        // R7 start-up images
        tag = "R7";
        ard(0); brd(0); sb_en = 1; sb_addr = 9'd2;
        @(negedge clk);
        chk(a_rdata == 16'h0100, "R7", "word 0 image", a_rdata, 16'h0100);
        chk(b_rdata == 8'h00, "R7", "byte 0 image", b_rdata, 0);
        chk(sb_rdata == PAT[23:16], "R7", "pattern byte 2", sb_rdata, PAT[23:16]);
        idle();

        // R2 lane order
        tag = "R2";
        awr(0, 2'b11, 16'h1234);
        @(negedge clk); idle(); brd(0);
        @(negedge clk);
        chk(b_rdata == 8'h34, "R2", "low byte of word 0", b_rdata, 8'h34);
        brd(1);
        @(negedge clk);
        chk(b_rdata == 8'h12, "R2", "high byte of word 0", b_rdata, 8'h12);
        idle(); b_en = 1; b_we = 1; b_addr = 9'd7; b_wdata = 8'hEE;
        @(negedge clk); idle(); ard(3);
        @(negedge clk);
        chk(a_rdata == 16'hEE06, "R2", "narrow write into high lane", a_rdata, 16'hEE06);

        // R3 byte enables
        tag = "R3";
        awr(4, 2'b01, 16'hAABB);
        @(negedge clk); awr(5, 2'b10, 16'hCCDD);
        @(negedge clk); awr(6, 2'b00, 16'hFFFF);
        @(negedge clk); ard(4);
        @(negedge clk);
        chk(a_rdata == 16'h09BB, "R3", "mask 01", a_rdata, 16'h09BB);
        ard(5);
        @(negedge clk);
        chk(a_rdata == 16'hCC0A, "R3", "mask 10", a_rdata, 16'hCC0A);
        ard(6);
        @(negedge clk);
        chk(a_rdata == 16'h0D0C, "R3", "mask 00", a_rdata, 16'h0D0C);

        // R5 read-first, same port and cross port
        tag = "R5";
        awr(8, 2'b11, 16'h7777); brd(16);
        @(negedge clk);
        chk(a_rdata == 16'h1110, "R5", "same-port old data", a_rdata, 16'h1110);
        chk(b_rdata == 8'h10, "R5", "cross-port old data", b_rdata, 8'h10);
        ard(8);
        @(negedge clk);
        chk(a_rdata == 16'h7777, "R5", "new data next cycle", a_rdata, 16'h7777);
        chk(b_rdata == 8'h77, "R5", "cross-port new data", b_rdata, 8'h77);

        // R6 disabled ports
        tag = "R6";
        idle(); a_we = 1; a_be = 2'b11; a_addr = 8'd9; a_wdata = 16'hFFFF;
        b_we = 1; b_addr = 9'd20; b_wdata = 8'h55;
        @(negedge clk);
        chk(a_rdata == 16'h7777, "R6", "wide holds while disabled", a_rdata, 16'h7777);
        chk(b_rdata == 8'h77, "R6", "narrow holds while disabled", b_rdata, 8'h77);
        idle(); ard(9); brd(20);
        @(negedge clk);
        chk(a_rdata == 16'h1312, "R6", "word 9 untouched", a_rdata, 16'h1312);
        chk(b_rdata == 8'h14, "R6", "byte 20 untouched", b_rdata, 8'h14);

        // R4 latency and hold
        tag = "R4";
        idle(); ard(10);
        @(negedge clk); idle();
        chk(a_rdata == 16'h1514, "R4", "one-cycle latency", a_rdata, 16'h1514);
        repeat (3) @(negedge clk);
        chk(a_rdata == 16'h1514, "R4", "held after three idle cycles", a_rdata, 16'h1514);

        // R9 one-way mode
        tag = "R9";
        idle(); sa_en = 1; sa_we = 1; sa_be = 2'b11; sa_addr = 8'd0; sa_wdata = 16'hBEEF;
        @(negedge clk); idle(); sb_en = 1; sb_we = 1; sb_addr = 9'd1; sb_wdata = 8'h42;
        @(negedge clk); idle(); sb_en = 1; sb_addr = 9'd1;
        @(negedge clk);
        chk(sb_rdata == 8'hBE, "R9", "narrow write ignored", sb_rdata, 8'hBE);
        chk(sa_rdata == 16'h0, "R9", "wide read stays zero", sa_rdata, 0);
        idle();

        // R8 random mixed traffic
        tag = "R8";
        for (int n = 0; n < 3000; n++) begin
            a_en = $urandom_range(0, 1); a_we = $urandom_range(0, 1); a_be = 2'($urandom);
            a_addr = ($urandom_range(0, 1) == 1) ? AWA'($urandom_range(0, 7)) : AWA'($urandom);
            a_wdata = 16'($urandom);
            b_en = $urandom_range(0, 1); b_we = $urandom_range(0, 1);
            b_addr = ($urandom_range(0, 1) == 1) ? AWB'($urandom_range(0, 15)) : AWB'($urandom);
            b_wdata = 8'($urandom);
            if (a_en && a_we && b_en && b_we && b_addr[AWB-1:1] == a_addr && a_be[b_addr[0]])
                b_we = 0;
            sa_en = $urandom_range(0, 1); sa_we = $urandom_range(0, 1); sa_be = 2'($urandom);
            sa_addr = AWA'($urandom_range(0, 7)); sa_wdata = 16'($urandom);
            sb_en = $urandom_range(0, 1); sb_we = $urandom_range(0, 1);
            sb_addr = AWB'($urandom_range(0, 15)); sb_wdata = 8'($urandom);
            @(negedge clk);
        end
        idle();
        @(negedge clk);
        live = 0;
        summary();
        $finish;
    end

endmodule